// File: doc/BRIEF.md
# Character Height Line Mapper

This block stretches an 18-row font glyph to a programmed number of scan lines. For every scan line of a character row it outputs the font row index to fetch. Each font row is shown a base number of times, and a spread-out subset of rows is shown one extra time. The subset is chosen by a rounded spacing rule, so the added lines are distributed across the glyph rather than grouped at one end.

A row-start pulse begins a character row and captures the height code. A line strobe then advances one displayed scan line per pulse. A valid output marks the lines of the row, and an end flag marks the final line. Vertical and horizontal zoom are handled elsewhere.

Top module: `char_height_mapper`

## Requirements
- R1: After reset, `line_valid` and `row_end` are low and `font_row` is 0.
- R2: On the clock edge after `row_start` is high, `line_valid` is high and `font_row` is 0, even when a row is already in progress. `row_start` wins over a simultaneous `line_step`.
- R3: While a row is active, each clock with `line_step` high advances by exactly one displayed line. A clock with `line_step` low leaves all outputs unchanged.
- R4: For a height code H from 19 to 32, let E = H−18 and M = floor(14/E + 0.5), with halves rounding up. Font row r, numbered 1..18, is shown twice when r > 2 and (r−2) is a multiple of M. Every other row is shown once.
- R5: For H from 33 to 46, every row is shown twice, and rows chosen by the R4 rule with E = H−32 are shown three times.
- R6: For H from 47 to 60, every row is shown three times, and rows chosen with E = H−46 are shown four times.
- R7: For H from 61 to 63, every row is shown four times, and rows chosen with E = H−60 are shown five times.
- R8: A height code of 18 or less shows each of the 18 rows exactly once.
- R9: No more than 16 rows of a glyph receive the extra repeat. At H = 32, rows 3..18 all receive it, for 34 lines in total.
- R10: `row_end` is high only on the last line of a row, which shows font row 17. A strobe on that line drops `line_valid` and returns `font_row` to 0.
- R11: `line_step` has no effect while no row is active: `line_valid` stays low.
- R12: The height code is sampled only at `row_start`. Changing it during a row does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| height_code | input | 6 | Programmed character height in scan lines |
| row_start | input | 1 | Begin a new character row (one-cycle pulse) |
| line_step | input | 1 | Advance one displayed scan line |
| font_row | output | 5 | Font row index 0..17 for the current line |
| line_valid | output | 1 | High while a row's lines are being produced |
| row_end | output | 1 | High on the last line of the row |

## Verification
Every one of the 64 height codes is walked through a complete character row. Each produced line is compared with a sequence the bench computes from the band and rounded-spacing rule. Codes at the band edges (18/19, 32/33, 46/47, 60/61) separate off-by-one errors in band selection from errors in the spacing itself. Codes with E of 3, 4 and 8 catch a rounding direction that is wrong. A stall cycle after every line shows that lines advance only on the strobe.

A height code that changes after the row starts tests capture at row start. Strobes while idle and a restart in the middle of a row test the control path separately from the mapping.

// File: rtl/chm_pkg.sv
package chm_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // Nearest integer of num/den (halves upward), found by search so
   // that no divider is built.
   function automatic int round_ratio(input int num, input int den);
      int r;
      r = num;
      if (den > 0) begin
         r = 1;
         for (int m = 1; m <= num; m++) begin
            if (2 * m * den <= 2 * num + den) r = m;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/chm_band_decode.sv
module chm_band_decode #(
   parameter int CODE_W    = 6,
   parameter int FONT_ROWS = 18,
   parameter int BAND_SPAN = 14,
   parameter int NUM_BANDS = 4,
   parameter int BASE_W    = 3,
   parameter int M_W       = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [BASE_W-1:0] base_rep,
   output logic [M_W-1:0]    spacing,
   output logic              extra_on
);

   always_comb begin
      int excess;
      int extra;
      int base_i;
      int m_i;
      excess = (int'(code) > FONT_ROWS) ? int'(code) - FONT_ROWS : 0;
      base_i = 1;
      extra  = 0;
      for (int b = 0; b < NUM_BANDS; b++) begin
         if (excess > b * BAND_SPAN) begin
            base_i = b + 1;
            extra  = excess - b * BAND_SPAN;
         end
      end
      m_i      = chm_pkg::round_ratio(BAND_SPAN, extra);
      base_rep = BASE_W'(base_i);
      spacing  = M_W'(m_i);
      extra_on = (extra > 0);
   end

endmodule

// File: rtl/chm_repeat_pick.sv
module chm_repeat_pick #(
   parameter int BASE_W    = 3,
   parameter int M_W       = 4,
   parameter int CAP_W     = 5,
   parameter int MAX_EXTRA = 16
) (
   input  logic [BASE_W-1:0] base_rep,
   input  logic              extra_on,
   input  logic [M_W-1:0]    to_next,
   input  logic [CAP_W-1:0]  extra_used,
   output logic [BASE_W-1:0] reps,
   output logic              take_extra
);

   logic cap_ok;

   assign cap_ok     = (int'(extra_used) < MAX_EXTRA);
   assign take_extra = extra_on && (to_next == '0) && cap_ok;
   assign reps       = base_rep + BASE_W'(take_extra);

endmodule

// File: rtl/chm_line_seq.sv
module chm_line_seq #(
   parameter int FONT_ROWS = 18,
   parameter int ROW_W     = 5,
   parameter int BASE_W    = 3,
   parameter int M_W       = 4,
   parameter int CAP_W     = 5,
   parameter int MAX_EXTRA = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_start,
   input  logic              line_step,
   input  logic [BASE_W-1:0] dec_base,
   input  logic [M_W-1:0]    dec_m,
   input  logic              dec_on,
   output logic [ROW_W-1:0]  row_idx,
   output logic              active,
   output logic              last_line
);

   chm_pkg::seq_state_e state;
   logic [BASE_W-1:0] rep_cnt;
   logic [M_W-1:0]    to_next;
   logic [CAP_W-1:0]  used;
   logic [BASE_W-1:0] cfg_base;
   logic [M_W-1:0]    cfg_m;
   logic              cfg_on;
   logic [BASE_W-1:0] reps;
   logic              take_extra;
   logic              final_rep;
   logic              final_row;

   chm_repeat_pick #(
      .BASE_W(BASE_W), .M_W(M_W), .CAP_W(CAP_W), .MAX_EXTRA(MAX_EXTRA)
   ) u_pick (
      .base_rep  (cfg_base),
      .extra_on  (cfg_on),
      .to_next   (to_next),
      .extra_used(used),
      .reps      (reps),
      .take_extra(take_extra)
   );

   assign active    = (state == chm_pkg::SEQ_RUN);
   assign final_rep = (rep_cnt == reps - BASE_W'(1));
   assign final_row = (row_idx == ROW_W'(FONT_ROWS - 1));
   assign last_line = active && final_rep && final_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= chm_pkg::SEQ_IDLE;
         row_idx  <= '0;
         rep_cnt  <= '0;
         to_next  <= '0;
         used     <= '0;
         cfg_base <= BASE_W'(1);
         cfg_m    <= M_W'(1);
         cfg_on   <= 1'b0;
      end else if (row_start) begin
         state    <= chm_pkg::SEQ_RUN;
         row_idx  <= '0;
         rep_cnt  <= '0;
         to_next  <= dec_m + M_W'(1);
         used     <= '0;
         cfg_base <= dec_base;
         cfg_m    <= dec_m;
         cfg_on   <= dec_on;
      end else if (active && line_step) begin
         if (!final_rep) begin
            rep_cnt <= rep_cnt + BASE_W'(1);
         end else if (final_row) begin
            state   <= chm_pkg::SEQ_IDLE;
            row_idx <= '0;
            rep_cnt <= '0;
         end else begin
            row_idx <= row_idx + ROW_W'(1);
            rep_cnt <= '0;
            to_next <= (to_next == '0) ? cfg_m - M_W'(1) : to_next - M_W'(1);
            if (take_extra) used <= used + CAP_W'(1);
         end
      end
   end

endmodule

// File: rtl/char_height_mapper.sv
module char_height_mapper #(
   parameter int CODE_W    = 6,
   parameter int FONT_ROWS = 18,
   parameter int BAND_SPAN = 14,
   parameter int MAX_EXTRA = 16,
   localparam int NUM_BANDS = ((1 << CODE_W) - 1 - FONT_ROWS + BAND_SPAN - 1) / BAND_SPAN,
   localparam int ROW_W     = $clog2(FONT_ROWS),
   localparam int BASE_W    = $clog2(NUM_BANDS + 2),
   localparam int M_W       = $clog2(BAND_SPAN + 2),
   localparam int CAP_W     = $clog2(MAX_EXTRA + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] height_code,
   input  logic              row_start,
   input  logic              line_step,
   output logic [ROW_W-1:0]  font_row,
   output logic              line_valid,
   output logic              row_end
);

   if (FONT_ROWS < 3) begin : g_bad_rows
      $error("FONT_ROWS must be at least 3");
   end
   if (BAND_SPAN < 1) begin : g_bad_span
      $error("BAND_SPAN must be positive");
   end
   if ((1 << CODE_W) - 1 <= FONT_ROWS) begin : g_bad_code
      $error("CODE_W too narrow for any stretch");
   end
   if (MAX_EXTRA < 1) begin : g_bad_cap
      $error("MAX_EXTRA must be positive");
   end

   logic [BASE_W-1:0] dec_base;
   logic [M_W-1:0]    dec_m;
   logic              dec_on;

   chm_band_decode #(
      .CODE_W(CODE_W), .FONT_ROWS(FONT_ROWS), .BAND_SPAN(BAND_SPAN),
      .NUM_BANDS(NUM_BANDS), .BASE_W(BASE_W), .M_W(M_W)
   ) u_dec (
      .code    (height_code),
      .base_rep(dec_base),
      .spacing (dec_m),
      .extra_on(dec_on)
   );

   chm_line_seq #(
      .FONT_ROWS(FONT_ROWS), .ROW_W(ROW_W), .BASE_W(BASE_W),
      .M_W(M_W), .CAP_W(CAP_W), .MAX_EXTRA(MAX_EXTRA)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_start(row_start),
      .line_step(line_step),
      .dec_base (dec_base),
      .dec_m    (dec_m),
      .dec_on   (dec_on),
      .row_idx  (font_row),
      .active   (line_valid),
      .last_line(row_end)
   );

endmodule

// File: rtl/char_height_mapper_chk.sv
module char_height_mapper_chk #(
   parameter int ROW_W     = 5,
   parameter int FONT_ROWS = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             row_start,
   input logic             line_step,
   input logic [ROW_W-1:0] font_row,
   input logic             line_valid,
   input logic             row_end
);

   // R2
   start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_start |=> (line_valid && font_row == '0));

   // R3
   hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && !line_step && !row_start) |=>
         ($stable(font_row) && line_valid && $stable(row_end)));

   // R3
   single_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && line_step && !row_start && !row_end) |=>
         (line_valid && (font_row == $past(font_row) ||
                         font_row == $past(font_row) + ROW_W'(1))));

   // R10
   end_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_end |-> (line_valid && font_row == ROW_W'(FONT_ROWS - 1)));

   // R10
   end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_end && line_step && !row_start) |=> (!line_valid && font_row == '0));

   // R11
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_valid && !row_start) |=> !line_valid);

endmodule

bind char_height_mapper char_height_mapper_chk #(
   .ROW_W(ROW_W), .FONT_ROWS(FONT_ROWS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_start (row_start),
   .line_step (line_step),
   .font_row  (font_row),
   .line_valid(line_valid),
   .row_end   (row_end)
);

// File: tb/char_height_mapper_bench.sv
module char_height_mapper_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] height_code = '0;
   logic       row_start = 1'b0;
   logic       line_step = 1'b0;
   logic [4:0] font_row;
   logic       line_valid;
   logic       row_end;

   int checks = 0;
   int bad = 0;
   bit finished = 1'b0;

   char_height_mapper u_char_height_mapper (
      .clk(clk), .rst_n(rst_n), .height_code(height_code),
      .row_start(row_start), .line_step(line_step),
      .font_row(font_row), .line_valid(line_valid), .row_end(row_end)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string band_tag(input int ch);
      if (ch <= 18) return "R8";
      if (ch <= 32) return "R4";
      if (ch <= 46) return "R5";
      if (ch <= 60) return "R6";
      return "R7";
   endfunction

   // Repeat count of font row r (1..18) for height code ch; used is the
   // number of rows already given an extra repeat.
   function automatic int model_reps(input int ch, input int r, input int used);
      int base;
      int e;
      int m;
      if (ch <= 18)      begin base = 1; e = 0;       end
      else if (ch <= 32) begin base = 1; e = ch - 18; end
      else if (ch <= 46) begin base = 2; e = ch - 32; end
      else if (ch <= 60) begin base = 3; e = ch - 46; end
      else               begin base = 4; e = ch - 60; end
      if (e == 0) return base;
      m = (28 + e) / (2 * e);
      if (r > 2 && ((r - 2) % m) == 0 && used < 16) return base + 1;
      return base;
   endfunction

   task automatic start_row(input int ch, input int later_code);
      height_code = 6'(ch);
      row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      height_code = 6'(later_code);  // R12: must not matter
   endtask

   // Walk a full row, checking every line and a stall after it.
   task automatic walk_row(input int ch, input int skip_lines);
      int used = 0;
      int lines = 0;
      string tag;
      tag = band_tag(ch);
      for (int r = 1; r <= 18; r++) begin
         int n;
         n = model_reps(ch, r, used);
         if (n > model_reps(ch <= 18 ? 0 : ch, 1, 0) && r > 2) used++;
         for (int k = 0; k < n; k++) begin
            bit is_last;
            is_last = (r == 18) && (k == n - 1);
            if (lines >= skip_lines) begin
               check(line_valid == 1'b1, tag, int'(line_valid), 1);
               check(int'(font_row) == r - 1, tag, int'(font_row), r - 1);
               check(row_end == is_last, "R10", int'(row_end), int'(is_last));
               line_step = 1'b0;
               @(negedge clk);
               check(int'(font_row) == r - 1, "R3", int'(font_row), r - 1);
            end
            line_step = 1'b1;
            @(negedge clk);
            line_step = 1'b0;
            lines++;
         end
      end
      check(line_valid == 1'b0, "R10", int'(line_valid), 0);
      check(font_row == '0, "R10", int'(font_row), 0);
      if (ch == 32) check(lines == 34, "R9", lines, 34);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         bad++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(line_valid == 1'b0, "R1", int'(line_valid), 0);
      check(row_end == 1'b0, "R1", int'(row_end), 0);
      check(font_row == '0, "R1", int'(font_row), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: strobes while idle
      line_step = 1'b1;
      repeat (3) @(negedge clk);
      line_step = 1'b0;
      check(line_valid == 1'b0, "R11", int'(line_valid), 0);

      // Full sweep of every height code
      for (int ch = 0; ch < 64; ch++) begin
         start_row(ch, (ch * 7 + 5) % 64);
         walk_row(ch, 0);
         line_step = 1'b1;
         @(negedge clk);
         line_step = 1'b0;
         check(line_valid == 1'b0, "R11", int'(line_valid), 0);
      end

      // R2: restart in the middle of a row, start beating a strobe
      start_row(40, 40);
      line_step = 1'b1;
      repeat (5) @(negedge clk);
      height_code = 6'd20;
      row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      line_step = 1'b0;
      height_code = 6'd63;
      check(line_valid == 1'b1, "R2", int'(line_valid), 1);
      check(font_row == '0, "R2", int'(font_row), 0);
      walk_row(20, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule